// File: doc/BRIEF.md
# RGB Strobe Decoder with Break-Before-Make

This block turns a 2-bit colour selection into gate enables for six LED power switches. It drives the red, green and blue emitters of a colour-sequential projector light path one after another. A map bit chooses between two wirings. In the common-anode map, three return switches stay closed and one cathode switch picks the colour. In the cathode-cathode-anode map, each colour closes its own set of switches.

When the selection changes, the switches that are no longer wanted open at once. Switches wanted in both the old and the new pattern stay closed. Switches that are newly wanted close only after a programmable dead time. The dead time is (code + 2) clock cycles. At the intended 111 ns clock tick, this gives 222 ns at code 0 and about 28.5 µs at code 255.

The block also outputs the index of the current setpoint that goes with the active colour. A transient current-limit enable is raised when the active channel has its limit bit set. The colour-select input is asynchronous, so it passes through a two-flop synchroniser before it is decoded.

Top module: `rgb_strobe_bbm`

## Requirements
- R1: With map_sel=0, the settled gate pattern (bit i = switch i+1) is 6'b000111 for select 0, 6'b001111 for 1, 6'b010111 for 2 and 6'b100111 for 3.
- R2: With map_sel=1, the settled pattern is 6'b000000 for select 0, 6'b100001 for 1, 6'b011100 for 2 and 6'b011010 for 3.
- R3: The setpoint index is 0 (none) for select 0, 1 (switch 4 setting) for select 1, 2 (switch 5) for 2 and 3 (switch 6) for 3, in both maps. It is 0 while the decoder is disabled.
- R4: A change of sel_in goes through two synchroniser flops. Switches leaving the closed state open on the third rising edge after the change is presented, and the index updates on that same edge.
- R5: Newly closing switches close exactly dead_code + 2 cycles after the edge on which the opening took place. No switch ever closes on the same edge that another switch opens.
- R6: A switch that is closed in both the old and the new pattern stays closed through the whole dead time.
- R7: While dec_en is low, all six gates are forced open on the next edge.
- R8: tlim_act is high only when the index is non-zero and lim_en[index-1] is set (bit 0 = switch 4, bit 1 = switch 5, bit 2 = switch 6).
- R9: A new selection that arrives during a dead time opens any unwanted switches at once and restarts the full dead time from the current gate state.
- R10: During reset, all gates are open, the index is 0 and tlim_act is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per dead-time step |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_in | input | 2 | Asynchronous colour selection |
| map_sel | input | 1 | Switch map choice (0 common anode, 1 cathode-cathode-anode) |
| dead_code | input | 8 | Dead-time code; dead time is code + 2 cycles |
| lim_en | input | 3 | Per-channel transient limit enables (switch 4, 5, 6) |
| dec_en | input | 1 | Decoder enable; low forces all switches open |
| sw_gate | output | 6 | Switch gate enables, bit i drives switch i+1 |
| cur_idx | output | 2 | Active current setpoint index, 0 = none |
| tlim_act | output | 1 | Transient current limit active for the current channel |

## Verification
The hardest case to reach is a selection change that lands inside a running dead time. Only that case exercises the restart rule, where a partly opened pattern becomes the new starting state. The stimulus sets a dead time of several cycles and steps the selection faster than that. This makes the pending closure get overtaken more than once in a row. A separate directed sequence pins the exact edge of opening and of closing for one change, including the switches that stay closed. A long-code run covers the far end of the dead-time range.

// File: rtl/rgb_strobe_bbm.sv
module rgb_strobe_bbm #(
  parameter int SEL_W  = 2,
  parameter int CODE_W = 8,
  parameter int SW_N   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic              map_sel,
  input  logic [CODE_W-1:0] dead_code,
  input  logic [2:0]        lim_en,
  input  logic              dec_en,
  output logic [SW_N-1:0]   sw_gate,
  output logic [SEL_W-1:0]  cur_idx,
  output logic              tlim_act
);
  localparam int CNT_W = CODE_W + 1;

  logic [SEL_W-1:0] s1, s2;
  logic [SW_N-1:0]  tgt_q, want;
  logic [CNT_W-1:0] cnt;
  logic             busy;

  function automatic logic [SW_N-1:0] decode(input logic m, input logic [SEL_W-1:0] s);
    logic [SW_N-1:0] r;
    if (!m) begin
      r = 6'b000111;
      if (s != 0) r[s + 2] = 1'b1;
    end else begin
      case (s)
        2'd1:    r = 6'b100001;
        2'd2:    r = 6'b011100;
        2'd3:    r = 6'b011010;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  assign want     = dec_en ? decode(map_sel, s2) : '0;
  assign tlim_act = (cur_idx != 0) && lim_en[cur_idx - 1'b1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0;
      sw_gate <= '0; tgt_q <= '0;
      cnt <= '0; busy <= 1'b0;
      cur_idx <= '0;
    end else begin
      s1 <= sel_in;
      s2 <= s1;
      cur_idx <= dec_en ? s2 : '0;
      if (want != tgt_q) begin
        sw_gate <= sw_gate & want;
        tgt_q   <= want;
        busy    <= |(want & ~sw_gate);
        cnt     <= CNT_W'(dead_code) + 1'b1;
      end else if (busy) begin
        if (cnt == 0) begin
          sw_gate <= tgt_q;
          busy    <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rgb_strobe_bbm_chk.sv
module rgb_strobe_bbm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dec_en,
  input logic [2:0] lim_en,
  input logic [5:0] sw_gate,
  input logic [1:0] cur_idx,
  input logic       tlim_act
);
  p_disable_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> sw_gate == 6'b0);

  p_no_make_on_break_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_gate & ~$past(sw_gate)) != 6'b0) |-> (($past(sw_gate) & ~sw_gate) == 6'b0));

  p_idx_none_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> cur_idx == 2'd0);

  p_tlim_needs_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tlim_act |-> (cur_idx != 2'd0));

  p_reset_state_r10: assert property (@(posedge clk)
    !rst_n |-> (sw_gate == 6'b0 && cur_idx == 2'd0));
endmodule

bind rgb_strobe_bbm rgb_strobe_bbm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .lim_en(lim_en),
  .sw_gate(sw_gate), .cur_idx(cur_idx), .tlim_act(tlim_act)
);

// File: tb/tb_rgb_strobe_bbm.sv
module tb_rgb_strobe_bbm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel_in = 2'd0;
  logic       map_sel = 1'b0;
  logic [7:0] dead_code = 8'd0;
  logic [2:0] lim_en = 3'b000;
  logic       dec_en = 1'b1;
  logic [5:0] sw_gate;
  logic [1:0] cur_idx;
  logic       tlim_act;

  int checks = 0, failures = 0, cyc = 0;
  string tag = "R10";
  bit model_on = 1'b0;

  rgb_strobe_bbm dut (.*);

  always #5 clk = ~clk;

  // behavioural reference
  int m_s1, m_s2, m_cur, m_close_at;
  logic [5:0] m_g, m_tgt;
  bit m_pend;

  function automatic logic [5:0] pattern(input bit m, input int s);
    logic [5:0] p = '0;
    int closed[$];
    if (!m) begin
      closed = {1, 2, 3};
      if (s > 0) closed.push_back(3 + s);
    end else if (s == 1) closed = {6, 1};
    else if (s == 2) closed = {5, 4, 3};
    else if (s == 3) closed = {5, 4, 2};
    foreach (closed[k]) p[closed[k]-1] = 1'b1;
    return p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_cur = 0; m_g = '0; m_tgt = '0; m_pend = 0;
    end else begin
      logic [5:0] t;
      t = dec_en ? pattern(map_sel, m_s2) : 6'b0;
      m_cur = dec_en ? m_s2 : 0;
      if (t != m_tgt) begin
        m_g = m_g & t;
        m_tgt = t;
        m_pend = (t & ~m_g) != 0;
        m_close_at = cyc + int'(dead_code) + 2;
      end else if (m_pend && cyc == m_close_at) begin
        m_g = m_tgt;
        m_pend = 0;
      end
      m_s2 = m_s1;
      m_s1 = int'(sel_in);
    end
    cyc++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (model_on) begin
    check({tag, " gates"}, sw_gate, m_g);
    check({tag, " index"}, cur_idx, m_cur);
    check({tag, " tlim"}, tlim_act, (m_cur != 0) && lim_en[m_cur-1]);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rotate(input int hold);
    for (int s = 0; s < 4; s++) begin sel_in = 2'(s); step(hold); end
  endtask

  initial begin
    step(3);
    check("R10 reset gates", sw_gate, 0);
    check("R10 reset index", cur_idx, 0);
    check("R10 reset tlim", tlim_act, 0);
    rst_n = 1'b1;
    model_on = 1'b1;

    tag = "R1"; rotate(12); rotate(12);

    // directed timing: map0, select 1 -> 2 with code 3
    tag = "R4"; dead_code = 8'd3; sel_in = 2'd1; step(12);
    check("R1 settled sel1", sw_gate, 6'b001111);
    sel_in = 2'd2; step(2);
    check("R4 before sync", sw_gate, 6'b001111);
    step(1);
    check("R4 opened on third edge", sw_gate, 6'b000111);
    check("R3 index switch5", cur_idx, 2);
    step(4);
    check("R6 common kept through dead time", sw_gate, 6'b000111);
    step(1);
    check("R5 closed after code+2", sw_gate, 6'b010111);

    tag = "R2"; map_sel = 1'b1; dead_code = 8'd2; rotate(10); rotate(10);
    sel_in = 2'd2; step(10);
    check("R2 settled sel2", sw_gate, 6'b011100);
    sel_in = 2'd3; step(3);
    check("R6 shared sw4 sw5 kept", sw_gate, 6'b011000);

    tag = "R8"; lim_en = 3'b001; map_sel = 1'b0; rotate(9);
    lim_en = 3'b110; map_sel = 1'b1; rotate(9);
    sel_in = 2'd3; step(6);
    check("R8 limit on switch6", tlim_act, 1);

    tag = "R7"; dec_en = 1'b0; step(1);
    check("R7 forced open", sw_gate, 0);
    step(5);
    check("R3 index none when off", cur_idx, 0);
    dec_en = 1'b1; step(10);

    tag = "R9"; dead_code = 8'd10; map_sel = 1'b0;
    for (int k = 0; k < 10; k++) begin sel_in = 2'(k % 4); step(4); end
    step(20);
    check("R9 settled after restarts", sw_gate, 6'b001111);

    tag = "R5"; dead_code = 8'hFF; sel_in = 2'd3; step(270);
    check("R5 long dead time settled", sw_gate, 6'b100111);
    map_sel = 1'b1; step(270);

    model_on = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule